// File: doc/BRIEF.md
# Non-volatile shadow register controller

This controller owns a 7-bit working register whose value drives a current-steering DAC, and keeps a persistent copy of that value in a small on-chip EEPROM. After reset it reads the EEPROM once and loads the stored code into the working register. Until that load completes it reports busy and accepts no write. After that it takes write commands from a serial-bus front end. Each command carries a 7-bit code and a destination flag. The flag selects either the working register alone or the register plus the EEPROM.

Writes to the EEPROM are allowed only while the write-enable input is high. A persistent write that arrives while that input is low still changes the working register, but nothing reaches the EEPROM and busy does not rise. An accepted EEPROM write raises a busy window that lasts a fixed number of clock cycles, taken from the programming time and the clock rate. Commands that arrive during that window are dropped. A status byte returns the working register and a ready bit to the bus for reads. The block also drives two static pins: the inverted write-enable level, and the enable for the alternate serial-clock path.

Top module: `nvreg_ctrl`

## Requirements
- R1: After reset, busy is high. Exactly one EEPROM read strobe is issued, and the value read back is loaded into the DAC code. Busy then falls.
- R2: A write command presented before the power-on load completes is ignored. The DAC code after boot equals the stored EEPROM value.
- R3: A command with `cmd_to_reg_i`=1 sets the DAC code to the command's code on the next clock edge. It causes no EEPROM write and no busy, whatever the level of `wp_n_i`.
- R4: A command with `cmd_to_reg_i`=0 while `wp_n_i`=1 updates the DAC code. In the same cycle it issues one `ee_wr_o` pulse carrying the code, and holds busy for exactly PROG_CYCLES = CLK_MHZ*PROG_US clock cycles.
- R5: A command with `cmd_to_reg_i`=0 while `wp_n_i`=0 updates the DAC code. It issues no EEPROM write and does not raise busy.
- R6: Any write command accepted while busy is ignored. The DAC code is unchanged and no EEPROM write occurs.
- R7: `status_o` bit 7 is 1 when ready and 0 when busy. Bits 6:0 always show the current DAC code.
- R8: `wp_o` is the inverse of `wp_n_i`, and `sclk_sw_en_o` equals `wp_n_i`.
- R9: A value programmed into the EEPROM is the value restored by the next reset, and the EEPROM can be reprogrammed repeatedly.
- R10: The extreme codes 0 and 127 are written and stored without change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n_i | input | 1 | EEPROM write enable (1 = writes allowed) |
| wp_o | output | 1 | Inverted write-enable level |
| sclk_sw_en_o | output | 1 | Enable for the alternate serial-clock path |
| cmd_valid_i | input | 1 | One-cycle write command strobe |
| cmd_to_reg_i | input | 1 | Destination: 1 = register only, 0 = register and EEPROM |
| cmd_code_i | input | 7 | Code carried by the command |
| busy_o | output | 1 | Boot load or EEPROM programming in progress |
| status_o | output | 8 | {ready, DAC code}, returned on bus reads |
| dac_code_o | output | 7 | Working register driving the DAC |
| ee_rd_o | output | 1 | EEPROM read strobe |
| ee_rd_data_i | input | 7 | EEPROM read data, valid RD_LAT cycles after the strobe |
| ee_wr_o | output | 1 | EEPROM write strobe |
| ee_wr_data_o | output | 7 | EEPROM write data |

## Verification
The hardest situation to reach from the ports is a command that lands during the short power-on load. The window is only a few cycles long and opens straight out of reset. The bench therefore drives a register write on the very cycle reset is released. It then confirms that the restored EEPROM value, not the command, ends up on the DAC. The busy window is probed by sending both a register write and a persistent write inside it, and by counting the exact number of busy cycles. A second reset confirms that the last programmed code is the one restored.

// File: rtl/nvreg_pkg.sv
package nvreg_pkg;

    localparam int CODE_W = 7;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        ST_BOOT_RD   = 2'd0,
        ST_BOOT_WAIT = 2'd1,
        ST_IDLE      = 2'd2,
        ST_PROG      = 2'd3
    } nv_state_e;

    typedef struct packed {
        logic  ready;
        code_t code;
    } status_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int prog_cycles(input int clk_mhz, input int us);
        return clk_mhz * us;
    endfunction

endpackage

// File: rtl/nvreg_timer.sv
module nvreg_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          zero_o
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R4: the window shrinks by one each idle cycle
    p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/nvreg_seq.sv
module nvreg_seq
    import nvreg_pkg::*;
#(
    parameter int TW          = 8,
    parameter int RD_LAT      = 2,
    parameter int PROG_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid_i,
    input  logic          cmd_to_reg_i,
    input  logic          wp_n_i,
    input  logic          tmr_zero_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output logic          busy_o,
    output logic          ee_rd_o,
    output logic          boot_load_o,
    output logic          accept_o,
    output logic          nv_start_o
);
    localparam logic [TW-1:0] RD_LOAD   = TW'(RD_LAT - 1);
    localparam logic [TW-1:0] PROG_LOAD = TW'(PROG_CYCLES - 1);

    nv_state_e state_q, state_d;

    always_comb begin
        accept_o    = (state_q == ST_IDLE) && cmd_valid_i;
        nv_start_o  = accept_o && !cmd_to_reg_i && wp_n_i;
        boot_load_o = (state_q == ST_BOOT_WAIT) && tmr_zero_i;
        ee_rd_o     = (state_q == ST_BOOT_RD) && !rst;
        busy_o      = (state_q != ST_IDLE);
        tmr_load_o  = (state_q == ST_BOOT_RD) || nv_start_o;
        tmr_val_o   = nv_start_o ? PROG_LOAD : RD_LOAD;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT_RD:   state_d = ST_BOOT_WAIT;
            ST_BOOT_WAIT: if (tmr_zero_i) state_d = ST_IDLE;
            ST_IDLE:      if (nv_start_o) state_d = ST_PROG;
            ST_PROG:      if (tmr_zero_i) state_d = ST_IDLE;
            default:      state_d = ST_BOOT_RD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_BOOT_RD;
        else     state_q <= state_d;
    end

    // R1: the boot read strobe is a single pulse
    p_rd_once_r1: assert property (@(posedge clk) disable iff (rst)
        ee_rd_o |=> !ee_rd_o);
    // R5: a persistent write never starts while protected
    p_wr_gate_r5: assert property (@(posedge clk) disable iff (rst)
        nv_start_o |-> wp_n_i);
    // R4: starting a program raises busy on the next cycle
    p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        nv_start_o |=> busy_o);
    // R6: nothing is accepted while busy
    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !accept_o);
    // R4: programming continues until the timer runs out
    p_prog_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROG && !tmr_zero_i) |=> (state_q == ST_PROG));
endmodule

// File: rtl/nvreg_shadow.sv
module nvreg_shadow
    import nvreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  code_t load_code_i,
    input  logic  wr_i,
    input  code_t wr_code_i,
    output code_t code_o
);
    code_t code_q;

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= '0;
        else if (load_i)
            code_q <= load_code_i;
        else if (wr_i)
            code_q <= wr_code_i;
    end

    assign code_o = code_q;

    // R3: an accepted write lands on the next edge
    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !load_i) |=> (code_q == $past(wr_code_i)));
    // R6: with no load and no write the code holds
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !wr_i) |=> $stable(code_q));
endmodule

// File: rtl/nvreg_ctrl.sv
module nvreg_ctrl
    import nvreg_pkg::*;
#(
    parameter int CLK_MHZ = 125,
    parameter int PROG_US = 10000,
    parameter int RD_LAT  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_n_i,
    output logic              wp_o,
    output logic              sclk_sw_en_o,
    input  logic              cmd_valid_i,
    input  logic              cmd_to_reg_i,
    input  logic [CODE_W-1:0] cmd_code_i,
    output logic              busy_o,
    output logic [CODE_W:0]   status_o,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              ee_rd_o,
    input  logic [CODE_W-1:0] ee_rd_data_i,
    output logic              ee_wr_o,
    output logic [CODE_W-1:0] ee_wr_data_o
);
    localparam int PROG_CYCLES = prog_cycles(CLK_MHZ, PROG_US);
    localparam int TW          = $clog2(max2(PROG_CYCLES, RD_LAT) + 1);

    logic          tmr_load, tmr_zero, busy, boot_load, accept, nv_start;
    logic [TW-1:0] tmr_val;
    code_t         code;
    status_t       st;

    nvreg_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    nvreg_seq #(
        .TW          (TW),
        .RD_LAT      (RD_LAT),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid_i  (cmd_valid_i),
        .cmd_to_reg_i (cmd_to_reg_i),
        .wp_n_i       (wp_n_i),
        .tmr_zero_i   (tmr_zero),
        .tmr_load_o   (tmr_load),
        .tmr_val_o    (tmr_val),
        .busy_o       (busy),
        .ee_rd_o      (ee_rd_o),
        .boot_load_o  (boot_load),
        .accept_o     (accept),
        .nv_start_o   (nv_start)
    );

    nvreg_shadow u_shadow (
        .clk         (clk),
        .rst         (rst),
        .load_i      (boot_load),
        .load_code_i (ee_rd_data_i),
        .wr_i        (accept),
        .wr_code_i   (cmd_code_i),
        .code_o      (code)
    );

    always_comb begin
        st.ready = !busy;
        st.code  = code;
    end

    assign status_o     = st;
    assign busy_o       = busy;
    assign dac_code_o   = code;
    assign ee_wr_o      = nv_start;
    assign ee_wr_data_o = cmd_code_i;
    assign wp_o         = !wp_n_i;
    assign sclk_sw_en_o = wp_n_i;

    // R4: each EEPROM write strobe moves the DAC to the written code
    p_wr_matches_dac_r4: assert property (@(posedge clk) disable iff (rst)
        ee_wr_o |=> (dac_code_o == $past(ee_wr_data_o)));
endmodule

// File: tb/nvreg_ctrl_tb.sv
module nvreg_ctrl_tb;
    localparam int CLK_MHZ = 125;
    localparam int PROG_US = 1;
    localparam int PROG_N  = CLK_MHZ * PROG_US;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wp_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_to_reg = 1'b0;
    logic [6:0] cmd_code = '0;
    logic wp_o, sclk_en, busy, ee_rd, ee_wr;
    logic [7:0] status;
    logic [6:0] dac, ee_q, ee_wdata;

    logic [6:0] mem = 7'h55;
    int wr_cnt = 0, rd_cnt = 0, cyc = 0;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    nvreg_ctrl #(.CLK_MHZ(CLK_MHZ), .PROG_US(PROG_US), .RD_LAT(2)) u_dut (
        .clk(clk), .rst(rst), .wp_n_i(wp_n), .wp_o(wp_o), .sclk_sw_en_o(sclk_en),
        .cmd_valid_i(cmd_valid), .cmd_to_reg_i(cmd_to_reg), .cmd_code_i(cmd_code),
        .busy_o(busy), .status_o(status), .dac_code_o(dac),
        .ee_rd_o(ee_rd), .ee_rd_data_i(ee_q), .ee_wr_o(ee_wr), .ee_wr_data_o(ee_wdata));

    // EEPROM model
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ee_rd) begin ee_q <= mem; rd_cnt <= rd_cnt + 1; end
        if (ee_wr) begin mem <= ee_wdata; wr_cnt <= wr_cnt + 1; end
    end

    function automatic void chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    typedef struct {
        string      tag;
        logic [6:0] dac;
        logic [7:0] st;
        int         wr;
    } exp_t;
    exp_t q[$];

    task automatic expect_now(input string tag, input logic [6:0] d, input bit rdy, input int w);
        exp_t it;
        it.tag = tag; it.dac = d; it.st = {rdy, d}; it.wr = w;
        q.push_back(it);
    endtask

    // monitor: compares outputs against queued expectations
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            chk({it.tag, " dac"}, int'(dac), int'(it.dac));
            chk({it.tag, " status"}, int'(status), int'(it.st));
            chk({it.tag, " ee writes"}, wr_cnt, it.wr);
        end
    end

    task automatic send(input logic to_reg, input logic [6:0] code);
        cmd_valid = 1'b1; cmd_to_reg = to_reg; cmd_code = code;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 1);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int c0;
        @(negedge clk);
        do_reset();
        // R2: a command on the release cycle is dropped
        send(1'b1, 7'h11);
        chk("R1 busy during boot", int'(busy), 1);
        wait_idle();
        expect_now("R1 R2 boot load", 7'h55, 1'b1, 0);
        @(negedge clk);
        chk("R1 single read strobe", rd_cnt, 1);

        // R8 static pins
        wp_n = 1'b0; #1;
        chk("R8 wp_o low-in", int'(wp_o), 1);
        chk("R8 sclk_en low-in", int'(sclk_en), 0);
        wp_n = 1'b1; #1;
        chk("R8 wp_o high-in", int'(wp_o), 0);
        chk("R8 sclk_en high-in", int'(sclk_en), 1);
        @(negedge clk);

        // R3 register-only write
        send(1'b1, 7'h12);
        expect_now("R3 reg write", 7'h12, 1'b1, 0);
        @(negedge clk);

        // R5 protected persistent write
        wp_n = 1'b0;
        send(1'b0, 7'h33);
        expect_now("R5 blocked nv write", 7'h33, 1'b1, 0);
        @(negedge clk);
        chk("R5 no busy", int'(busy), 0);

        // R4 R10 persistent write of max code, R6 writes while busy
        wp_n = 1'b1;
        send(1'b0, 7'h7F);
        c0 = cyc;
        expect_now("R4 R10 nv write 127 busy", 7'h7F, 1'b0, 1);
        send(1'b1, 7'h01);
        expect_now("R6 reg write while busy", 7'h7F, 1'b0, 1);
        send(1'b0, 7'h02);
        expect_now("R6 nv write while busy", 7'h7F, 1'b0, 1);
        wait_idle();
        chk("R4 busy length", cyc - c0, PROG_N);
        expect_now("R4 R7 ready after program", 7'h7F, 1'b1, 1);
        chk("R9 stored 127", int'(mem), 7'h7F);
        @(negedge clk);

        // R10 minimum code, then R9 reprogram
        send(1'b0, 7'h00);
        expect_now("R10 nv write 0", 7'h00, 1'b0, 2);
        wait_idle();
        send(1'b0, 7'h2A);
        expect_now("R9 reprogram", 7'h2A, 1'b0, 3);
        wait_idle();
        send(1'b1, 7'h05);
        expect_now("R3 reg differs from stored", 7'h05, 1'b1, 3);
        @(negedge clk);

        // R9 reset restores last programmed value
        do_reset();
        @(negedge clk);
        wait_idle();
        expect_now("R9 restore after reset", 7'h2A, 1'b1, 3);
        @(negedge clk);
        chk("R1 second boot read", rd_cnt, 2);

        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule